// File: doc/BRIEF.md
# Bus master data tenure controller

This block runs the data phase of a bus master on a split-transaction bus with a 64-bit data path. The data path is split into a high and a low 32-bit half. A write request is taken only while the controller is idle. The request carries four 64-bit words, eight byte enables, a burst flag and a direct-store flag. The controller then waits for a data grant. A grant counts only while no other master signals that it is using the data bus. Once the grant is qualified, the controller claims the bus and drives its beats.

Each beat stays on the bus until the target acknowledges it. A single transfer is one beat long and a burst is four beats long. The tenure ends after the final acknowledge or at once on a transfer error. After it ends, the busy line is driven inactive for one cycle before its driver lets go. The data halves stop driving as soon as the tenure ends. A one-cycle done pulse reports the end of the tenure and flags whether an error ended it.

Top module: `dten_master`

## Requirements
- R1: After reset, `req_ready` is 1 and `busy_out`, `busy_oe`, `data_oe_hi`, `data_oe_lo`, `done`, `done_err`, `dh` and `dl` are all 0.
- R2: A request on `req_valid` is accepted only while `req_ready` is 1. A request presented while the controller is not idle has no effect on the data that is later driven.
- R3: A grant is qualified only when `grant` is 1 and `busy_in` is 0 at the same clock edge. `busy_out`, `busy_oe` and `data_oe_hi` rise in the cycle after the qualified grant, and an unqualified grant leaves them at 0.
- R4: Beat n is word n of the request, taken from bits [64n+63:64n]. `dh` carries word bits [63:32] and `dl` carries word bits [31:0]. Byte lane k is word bits [8k+7:8k]. A lane whose `req_be[k]` is 0 is driven as zero.
- R5: While the tenure is open and `ack` is low, the current beat is held. The next beat appears in the cycle after each `ack`.
- R6: With `req_burst` at 0 the tenure carries exactly one beat. With `req_burst` at 1 it carries exactly four beats.
- R7: With `req_direct` at 1, `data_oe_lo` stays 0 and `dl` stays 0 for the whole tenure. Only the high half is driven.
- R8: In the cycle after the final `ack`, `busy_out`, `data_oe_hi` and `data_oe_lo` are 0 and `busy_oe` is 1. In the cycle after that, `busy_oe` is 0.
- R9: `err` sampled during the tenure ends it in the next cycle with the same release as R8. This happens however many beats remain, and `err` takes precedence over an `ack` at the same edge.
- R10: `done` is high for exactly the release cycle of R8 or R9. `done_err` is 1 in that cycle only if `err` ended the tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request strobe |
| req_burst | input | 1 | 1 = four-beat burst, 0 = single beat |
| req_direct | input | 1 | 1 = direct-store, high half only |
| req_be | input | 8 | Byte lane enables, bit k = data bits [8k+7:8k] |
| req_data | input | 256 | Four 64-bit words, word n at [64n+63:64n] |
| req_ready | output | 1 | Controller is idle and takes a request |
| grant | input | 1 | Data bus grant from the arbiter |
| busy_in | input | 1 | Another master holds the data bus |
| ack | input | 1 | Target acknowledge of the current beat |
| err | input | 1 | Transfer error, ends the tenure |
| busy_out | output | 1 | Data-bus-busy value driven by this master |
| busy_oe | output | 1 | Drive enable of the busy line |
| dh | output | 32 | High data half |
| dl | output | 32 | Low data half |
| data_oe_hi | output | 1 | Drive enable of the high half |
| data_oe_lo | output | 1 | Drive enable of the low half |
| done | output | 1 | One-cycle end-of-tenure pulse |
| done_err | output | 1 | Tenure ended by error (valid with done) |

## Verification
A qualified grant shows on `busy_out` and the first beat one edge later, and each `ack` moves the bus to the next beat one edge later. The release pattern and `done` appear one edge after the final `ack` or after `err`, and the busy drive enable falls one edge after that. The bench drives inputs just after a rising edge and checks each of these results just after the edge at which it is due. The monitor compares a beat at the falling edge of the cycle in which that beat is acknowledged, against the scoreboard entry the driver queued when it raised `ack`. A stall cycle without `ack` queues nothing, so a beat that moved too early shows up as a mismatch.

// File: rtl/dten_pkg.sv
// Package: shared state type and byte-lane width for the data tenure controller.
package dten_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } dten_state_t;

    localparam int LANE_W = 8;
endpackage

// File: rtl/dten_fsm.sv
// Tenure sequencer: takes a request, waits for a qualified grant, counts
// acknowledged beats and raises a one-cycle release flag at the end.
// Assumes BEATS is a power of two greater than one.
module dten_fsm
    import dten_pkg::*;
#(
    parameter int BEATS = 4,
    localparam int BW = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_fire,
    input  logic          req_burst,
    input  logic          grant,
    input  logic          busy_in,
    input  logic          ack,
    input  logic          err,
    output logic          idle,
    output logic          in_xfer,
    output logic [BW-1:0] beat,
    output logic          rel,
    output logic          rel_err
);
    dten_state_t   state_q;
    logic [BW-1:0] beat_q;
    logic          burst_q;
    logic          rel_q;
    logic          rel_err_q;
    logic [BW-1:0] last_idx;

    // Index of the final beat for the latched transfer size.
    always_comb begin
        last_idx = burst_q ? BW'(BEATS - 1) : '0;
    end

    // State, beat counter and release flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            beat_q    <= '0;
            burst_q   <= 1'b0;
            rel_q     <= 1'b0;
            rel_err_q <= 1'b0;
        end else begin
            rel_q     <= 1'b0;
            rel_err_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_fire) begin
                        state_q <= ST_WAIT;
                        burst_q <= req_burst;
                    end
                end
                ST_WAIT: begin
                    if (grant && !busy_in) begin
                        state_q <= ST_XFER;
                        beat_q  <= '0;
                    end
                end
                ST_XFER: begin
                    if (err) begin
                        state_q   <= ST_IDLE;
                        rel_q     <= 1'b1;
                        rel_err_q <= 1'b1;
                    end else if (ack) begin
                        if (beat_q == last_idx) begin
                            state_q <= ST_IDLE;
                            rel_q   <= 1'b1;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign idle    = (state_q == ST_IDLE);
    assign in_xfer = (state_q == ST_XFER);
    assign beat    = beat_q;
    assign rel     = rel_q;
    assign rel_err = rel_err_q;
endmodule

// File: rtl/dten_lanes.sv
// Data path: holds the request words, picks the current beat, zeroes
// disabled byte lanes and silences the low half for direct-store.
// Assumes load only happens while no tenure is open.
module dten_lanes
    import dten_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int BEATS  = 4,
    localparam int DATA_W = 2 * HALF_W,
    localparam int LANES  = DATA_W / LANE_W,
    localparam int BW     = $clog2(BEATS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [BEATS*DATA_W-1:0] req_data,
    input  logic [LANES-1:0]        req_be,
    input  logic                    req_direct,
    input  logic [BW-1:0]           beat,
    input  logic                    drive,
    output logic [HALF_W-1:0]       dh,
    output logic [HALF_W-1:0]       dl,
    output logic                    lo_en
);
    logic [DATA_W-1:0] words_q [BEATS];
    logic [LANES-1:0]  be_q;
    logic              direct_q;
    logic [DATA_W-1:0] sel_word;
    logic [DATA_W-1:0] masked;

    // Capture the request attributes when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            be_q     <= '0;
            direct_q <= 1'b0;
        end else if (load) begin
            be_q     <= req_be;
            direct_q <= req_direct;
        end
    end

    // Capture the request words when a request is accepted.
    always_ff @(posedge clk) begin
        if (load) begin
            for (int w = 0; w < BEATS; w++) begin
                words_q[w] <= req_data[w*DATA_W +: DATA_W];
            end
        end
    end

    // Current beat selection.
    always_comb begin
        sel_word = words_q[beat];
    end

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign masked[k*LANE_W +: LANE_W] =
                be_q[k] ? sel_word[k*LANE_W +: LANE_W] : '0;
        end
    endgenerate

    assign lo_en = drive && !direct_q;
    assign dh    = drive ? masked[DATA_W-1:HALF_W] : '0;
    assign dl    = lo_en ? masked[HALF_W-1:0] : '0;
endmodule

// File: rtl/dten_master.sv
// Top of the data tenure controller: joins the sequencer and the data path
// and forms the busy line and the output enables. The busy line is driven
// inactive for one cycle after the tenure before its driver is released.
module dten_master
    import dten_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int BEATS  = 4,
    localparam int DATA_W = 2 * HALF_W,
    localparam int LANES  = DATA_W / LANE_W,
    localparam int BW     = $clog2(BEATS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_burst,
    input  logic                    req_direct,
    input  logic [LANES-1:0]        req_be,
    input  logic [BEATS*DATA_W-1:0] req_data,
    output logic                    req_ready,
    input  logic                    grant,
    input  logic                    busy_in,
    input  logic                    ack,
    input  logic                    err,
    output logic                    busy_out,
    output logic                    busy_oe,
    output logic [HALF_W-1:0]       dh,
    output logic [HALF_W-1:0]       dl,
    output logic                    data_oe_hi,
    output logic                    data_oe_lo,
    output logic                    done,
    output logic                    done_err
);
    logic          idle;
    logic          in_xfer;
    logic [BW-1:0] beat;
    logic          rel;
    logic          rel_err;
    logic          req_fire;
    logic          lo_en;

    assign req_fire = req_valid && idle;

    dten_fsm #(.BEATS(BEATS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_fire  (req_fire),
        .req_burst (req_burst),
        .grant     (grant),
        .busy_in   (busy_in),
        .ack       (ack),
        .err       (err),
        .idle      (idle),
        .in_xfer   (in_xfer),
        .beat      (beat),
        .rel       (rel),
        .rel_err   (rel_err)
    );

    dten_lanes #(.HALF_W(HALF_W), .BEATS(BEATS)) u_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (req_fire),
        .req_data   (req_data),
        .req_be     (req_be),
        .req_direct (req_direct),
        .beat       (beat),
        .drive      (in_xfer),
        .dh         (dh),
        .dl         (dl),
        .lo_en      (lo_en)
    );

    assign req_ready  = idle;
    assign busy_out   = in_xfer;
    assign busy_oe    = in_xfer || rel;
    assign data_oe_hi = in_xfer;
    assign data_oe_lo = lo_en;
    assign done       = rel;
    assign done_err   = rel_err;
endmodule

// File: rtl/dten_master_chk.sv
// Checker for the data tenure controller, attached to every instance by bind.
module dten_master_chk #(
    parameter int HALF_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grant,
    input logic              busy_in,
    input logic              ack,
    input logic              err,
    input logic              busy_out,
    input logic              busy_oe,
    input logic [HALF_W-1:0] dh,
    input logic [HALF_W-1:0] dl,
    input logic              data_oe_hi,
    input logic              data_oe_lo,
    input logic              done,
    input logic              done_err
);
    // R3
    busy_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_out) |-> $past(grant && !busy_in));

    // R5
    hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_out && !ack && !err) |=> (busy_out && $stable(dh) && $stable(dl)));

    // R7
    lo_needs_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_lo |-> data_oe_hi);

    // R8
    release_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_out) |-> (busy_oe && !data_oe_hi && !data_oe_lo));

    // R8
    release_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_oe && !busy_out) |=> !busy_oe);

    // R9
    err_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_out && err) |=> (!busy_out && done && done_err));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy_out) && !busy_out));
endmodule

bind dten_master dten_master_chk #(.HALF_W(HALF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (grant),
    .busy_in    (busy_in),
    .ack        (ack),
    .err        (err),
    .busy_out   (busy_out),
    .busy_oe    (busy_oe),
    .dh         (dh),
    .dl         (dl),
    .data_oe_hi (data_oe_hi),
    .data_oe_lo (data_oe_lo),
    .done       (done),
    .done_err   (done_err)
);

// File: tb/dten_master_test.sv
// Scoreboard bench for the data tenure controller.
module dten_master_test;
    localparam int HALF_W = 32;
    localparam int BEATS  = 4;
    localparam int DATA_W = 64;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic                    req_burst = 1'b0;
    logic                    req_direct = 1'b0;
    logic [7:0]              req_be = '0;
    logic [BEATS*DATA_W-1:0] req_data = '0;
    logic                    req_ready;
    logic                    grant = 1'b0;
    logic                    busy_in = 1'b0;
    logic                    ack = 1'b0;
    logic                    err = 1'b0;
    logic                    busy_out, busy_oe, data_oe_hi, data_oe_lo, done, done_err;
    logic [HALF_W-1:0]       dh, dl;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [31:0] hi;
        logic [31:0] lo;
        logic        lo_en;
    } beat_t;
    beat_t sb_q[$];

    dten_master #(.HALF_W(HALF_W), .BEATS(BEATS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_burst(req_burst),
        .req_direct(req_direct), .req_be(req_be), .req_data(req_data),
        .req_ready(req_ready), .grant(grant), .busy_in(busy_in), .ack(ack),
        .err(err), .busy_out(busy_out), .busy_oe(busy_oe), .dh(dh), .dl(dl),
        .data_oe_hi(data_oe_hi), .data_oe_lo(data_oe_lo), .done(done),
        .done_err(done_err)
    );

    always #5 clk = ~clk;

    // Counts one comparison and reports it on mismatch.
    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Expected bus content of beat b, built from the requirement R4.
    function automatic beat_t expect_beat(input logic [BEATS*DATA_W-1:0] d,
                                          input logic [7:0] be, input bit direct, input int b);
        beat_t e;
        logic [63:0] w;
        w = d[b*DATA_W +: DATA_W];
        for (int k = 0; k < 8; k++) if (!be[k]) w[k*8 +: 8] = 8'h00;
        e.hi    = w[63:32];
        e.lo    = direct ? 32'h0 : w[31:0];
        e.lo_en = !direct;
        return e;
    endfunction

    // Monitor: compares each acknowledged beat with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && ack && !err && data_oe_hi) begin
            if (sb_q.size() == 0) begin
                check(64'd1, 64'd0, "R6 beat acknowledged with empty scoreboard");
            end else begin
                beat_t e;
                e = sb_q.pop_front();
                check({32'h0, dh}, {32'h0, e.hi}, "R4/R5 dh beat");
                check({32'h0, dl}, {32'h0, e.lo}, "R4/R7 dl beat");
                check({63'h0, data_oe_lo}, {63'h0, e.lo_en}, "R7 data_oe_lo");
            end
        end
    end

    // Driver: runs one tenure. err_beat < 0 means no error.
    task automatic tenure(input bit burst, input bit direct, input logic [7:0] be,
                          input logic [BEATS*DATA_W-1:0] d, input int err_beat,
                          input bit stall, input bit poke_busy);
        int nb;
        bit ended;
        nb = burst ? BEATS : 1;
        check({63'h0, req_ready}, 64'd1, "R2 ready before request");
        req_valid = 1'b1; req_burst = burst; req_direct = direct; req_be = be; req_data = d;
        step();
        req_valid = 1'b0;
        check({63'h0, req_ready}, 64'd0, "R2 not ready while waiting");
        // R2: a request while waiting must not replace the captured one
        req_valid = 1'b1; req_burst = !burst; req_direct = !direct; req_be = ~be; req_data = ~d;
        if (poke_busy) begin
            busy_in = 1'b1; grant = 1'b1;
            for (int i = 0; i < 2; i++) begin
                step();
                check({63'h0, busy_out}, 64'd0, "R3 grant with busy_in set");
                check({63'h0, busy_oe}, 64'd0, "R3 busy_oe with busy_in set");
            end
        end else begin
            step();
        end
        req_valid = 1'b0;
        busy_in = 1'b0; grant = 1'b1;
        step();
        grant = 1'b0;
        check({61'h0, busy_out, busy_oe, data_oe_hi}, 64'd7, "R3 busy and data drive after grant");
        ended = 1'b0;
        for (int b = 0; b < nb && !ended; b++) begin
            beat_t e;
            e = expect_beat(d, be, direct, b);
            if (stall) begin
                step();
                check({32'h0, dh}, {32'h0, e.hi}, "R5 beat held without ack");
            end
            if (b == err_beat) begin
                err = 1'b1; ack = 1'b1;
                step();
                err = 1'b0; ack = 1'b0;
                ended = 1'b1;
            end else begin
                sb_q.push_back(e);
                ack = 1'b1;
                step();
                ack = 1'b0;
                if (b < nb - 1)
                    check({63'h0, busy_out}, 64'd1, "R6 tenure open before last beat");
            end
        end
        check({60'h0, busy_out, data_oe_hi, data_oe_lo, busy_oe}, 64'd1, "R8/R9 release cycle");
        check({62'h0, done, done_err}, {62'h0, 1'b1, ended}, "R10 done and done_err");
        check({32'h0, dh}, 64'd0, "R8 dh quiet after release");
        ack = 1'b1;
        step();
        ack = 1'b0;
        check({62'h0, busy_oe, done}, 64'd0, "R8/R10 busy_oe and done off");
        check({63'h0, data_oe_hi}, 64'd0, "R9 no beats after end");
        check(64'(sb_q.size()), 64'd0, "R6 all expected beats acknowledged");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [BEATS*DATA_W-1:0] d;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check({62'h0, req_ready, busy_out}, 64'd2, "R1 ready/busy after reset");
        check({60'h0, busy_oe, data_oe_hi, data_oe_lo, done}, 64'd0, "R1 enables after reset");
        check({32'h0, dh ^ dl}, 64'd0, "R1 data after reset");
        d = {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
             64'h1111_2222_3333_4444, 64'hA5A5_5A5A_C3C3_3C3C};
        tenure(1'b0, 1'b0, 8'hFF, d, -1, 1'b0, 1'b1);   // R6 single beat
        tenure(1'b1, 1'b0, 8'h5A, d, -1, 1'b1, 1'b0);   // R4 R5 burst with stalls
        tenure(1'b0, 1'b1, 8'hF0, ~d, -1, 1'b0, 1'b0);  // R7 direct single
        tenure(1'b1, 1'b1, 8'hC3, d, -1, 1'b1, 1'b1);   // R7 direct burst
        tenure(1'b1, 1'b0, 8'hFF, ~d, 2, 1'b1, 1'b0);   // R9 error mid-burst
        tenure(1'b0, 1'b0, 8'h0F, d, 0, 1'b0, 1'b1);    // R9 error on single
        tenure(1'b1, 1'b0, 8'h81, {d[127:0], d[255:128]}, -1, 1'b0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule